// File: doc/BRIEF.md
# Transmit Byte Buffer with Start Threshold

This block sits between a host's slave write port and a serial transmitter. The host fills a byte-wide queue one byte per write cycle. Each byte carries a flag that marks the last byte of a frame. The transmit side drains the queue through a valid/ready pair. The block also drives a start request that tells the transmitter it may begin sending the preamble of the frame at the head of the queue.

A write can arrive in one of two ways. The first is a chip-select strobe together with a register address. The second is a dedicated queue strobe that needs no address. A 2-bit threshold setting lives at a second register address. The start request rises at the earliest of three events: the head frame holds enough bytes, a complete frame is stored, or the queue fills. Once raised, the request stays up until the final byte of that frame has left the queue. A software reset input returns the block to its reset state without touching the system reset.

Top module: `tx_stage_buffer`

## Requirements
- R1: With `host_sel`=1, `fifo_sel`=0, `host_rw`=0 and `host_addr`=5'b00001, the byte on `host_data` and the flag on `host_eof` are appended to the queue at that clock edge.
- R2: An addressed strobe with `host_rw`=1, or with any address other than 5'b00001 and 5'b00010, leaves both the queue and the threshold unchanged.
- R3: With `fifo_sel`=1, `host_sel`=0 and `host_rw`=0, the byte is appended whatever the value of `host_addr`.
- R4: In a cycle where `host_sel` and `fifo_sel` are both 1, no write of any kind takes place.
- R5: A strobe held active over consecutive cycles performs one write per cycle, with no idle cycle needed between writes.
- R6: Bytes leave in the order they were written. Each byte leaves with the end-of-frame flag that was written with it.
- R7: An addressed write to 5'b00010 loads `host_data[1:0]` as the threshold code: 00 means 4 bytes, 01 means 16, 10 means 64 and 11 means 112.
- R8: After reset the code is 10. `start_req` rises once the stored byte count reaches the selected threshold.
- R9: `start_req` is 1 whenever at least one complete frame (a byte flagged end-of-frame) is stored, whatever the threshold.
- R10: `start_req` is 1 whenever the queue holds DEPTH (136) bytes.
- R11: A write that arrives while the queue is full is dropped. It sets `overflow`, which stays at 1 until a reset.
- R12: `rd_valid` is 1 while the queue is non-empty. `rd_data` and `rd_eof` show the oldest byte. One entry is removed on each clock edge where `rd_valid` and `rd_ready` are both 1.
- R13: `soft_rst` empties the queue, clears `overflow` and the start state, and restores threshold code 10.
- R14: Once `start_req` is 1, it stays 1 until the byte flagged end-of-frame is removed, even if the count falls below the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| soft_rst | input | 1 | Synchronous software reset of queue, flags and threshold |
| host_sel | input | 1 | Addressed chip-select strobe |
| fifo_sel | input | 1 | Address-free queue strobe |
| host_rw | input | 1 | 1 = read cycle, 0 = write cycle |
| host_addr | input | 5 | Register address for addressed cycles |
| host_data | input | 8 | Write data |
| host_eof | input | 1 | Marks the written byte as the last byte of a frame |
| rd_data | output | 8 | Oldest stored byte |
| rd_eof | output | 1 | End-of-frame flag of the oldest byte |
| rd_valid | output | 1 | Queue is non-empty |
| rd_ready | input | 1 | Transmitter takes the oldest byte |
| start_req | output | 1 | Transmitter may begin the head frame |
| overflow | output | 1 | Sticky flag: a write was dropped while full |

## Verification
Directed sequences drive each write path on its own: addressed writes at the queue address, at the threshold address, and at unrelated addresses or with the read flag set. They also drive direct strobes with random addresses and cycles where both strobes are active, so that an accepted write shows up as a change in queue contents and a blocked one does not. For each threshold code the queue is filled to one byte below the threshold and then to the threshold itself, which pins the exact byte count at which the start request rises. Separate sequences separate the three start causes: a short complete frame under a large threshold, a fill to capacity with no frame end, and a partial drain after the start to show the request is held. A long random mix of strobes, pops and rare software resets is then compared each cycle against a queue model kept in the bench.

// File: rtl/txb_pkg.sv
package txb_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;
    localparam logic [ADDR_W-1:0] QUEUE_ADDR = 5'b00001;
    localparam logic [ADDR_W-1:0] THR_ADDR   = 5'b00010;

    typedef enum logic [1:0] {
        THR_4   = 2'b00,
        THR_16  = 2'b01,
        THR_64  = 2'b10,
        THR_112 = 2'b11
    } txb_thr_e;

    localparam txb_thr_e THR_DEFAULT = THR_64;

    typedef struct packed {
        logic              eof;
        logic [DATA_W-1:0] data;
    } txb_entry_t;

    typedef struct packed {
        logic       push;
        logic       cfg;
        txb_thr_e   code;
        txb_entry_t ent;
    } txb_wreq_t;

    function automatic logic [31:0] thr_bytes(txb_thr_e c);
        unique case (c)
            THR_4:   return 32'd4;
            THR_16:  return 32'd16;
            THR_64:  return 32'd64;
            default: return 32'd112;
        endcase
    endfunction

endpackage

// File: rtl/txb_host_decode.sv
module txb_host_decode
    import txb_pkg::*;
(
    input  logic              host_sel,
    input  logic              fifo_sel,
    input  logic              host_rw,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_data,
    input  logic              host_eof,
    output txb_wreq_t         wreq
);
    logic one_strobe;
    logic addr_wr;

    always_comb begin
        // the two strobes are mutually exclusive; both active blocks the cycle
        one_strobe   = host_sel ^ fifo_sel;
        addr_wr      = host_sel & ~fifo_sel & ~host_rw;
        wreq.push    = one_strobe & ~host_rw & (fifo_sel | (host_addr == QUEUE_ADDR));
        wreq.cfg     = addr_wr & (host_addr == THR_ADDR);
        wreq.code    = txb_thr_e'(host_data[1:0]);
        wreq.ent.eof = host_eof;
        wreq.ent.data = host_data;
    end
endmodule

// File: rtl/txb_thr_reg.sv
module txb_thr_reg
    import txb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     load,
    input  txb_thr_e code_in,
    output txb_thr_e code_q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            code_q <= THR_DEFAULT;
        end else if (load) begin
            code_q <= code_in;
        end
    end
endmodule

// File: rtl/txb_store.sv
module txb_store
    import txb_pkg::*;
#(
    parameter  int DEPTH = 136,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  txb_entry_t       wr_ent,
    input  logic             take,
    output txb_entry_t       head,
    output logic             valid,
    output logic             full,
    output logic [CNT_W-1:0] occ,
    output logic [CNT_W-1:0] frames,
    output logic             ovf,
    output logic             pop_eof
);
    txb_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             do_push, do_pop, push_eof;

    function automatic logic [PTR_W-1:0] step_ptr(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        valid    = (occ != '0);
        full     = (occ == CNT_W'(DEPTH));
        head     = mem[rp];
        do_push  = push & ~full;
        do_pop   = take & valid;
        push_eof = do_push & wr_ent.eof;
        pop_eof  = do_pop & head.eof;
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= wr_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp     <= '0;
            rp     <= '0;
            occ    <= '0;
            frames <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wp <= step_ptr(wp);
            if (do_pop)  rp <= step_ptr(rp);
            unique case ({do_push, do_pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
            unique case ({push_eof, pop_eof})
                2'b10:   frames <= frames + 1'b1;
                2'b01:   frames <= frames - 1'b1;
                default: frames <= frames;
            endcase
            if (push && full) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/txb_start_ctl.sv
module txb_start_ctl #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [CNT_W-1:0] occ,
    input  logic [CNT_W-1:0] frames,
    input  logic             full,
    input  logic [31:0]      thr_n,
    input  logic             pop_eof,
    output logic             start_req
);
    logic started;
    logic cond;

    always_comb begin
        cond      = (frames != '0) | full | (32'(occ) >= thr_n);
        start_req = started | cond;
    end

    // once granted, the grant is held until the frame's last byte leaves
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            started <= 1'b0;
        end else begin
            started <= (started | cond) & ~pop_eof;
        end
    end
endmodule

// File: rtl/tx_stage_buffer.sv
module tx_stage_buffer
    import txb_pkg::*;
#(
    parameter  int DEPTH = 136,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        soft_rst,
    input  logic        host_sel,
    input  logic        fifo_sel,
    input  logic        host_rw,
    input  logic [4:0]  host_addr,
    input  logic [7:0]  host_data,
    input  logic        host_eof,
    output logic [7:0]  rd_data,
    output logic        rd_eof,
    output logic        rd_valid,
    input  logic        rd_ready,
    output logic        start_req,
    output logic        overflow
);
    txb_wreq_t        wreq;
    txb_thr_e         code_q;
    txb_entry_t       head;
    logic             full, pop_eof;
    logic [CNT_W-1:0] occ, frames;
    logic [31:0]      thr_n;

    txb_host_decode u_dec (
        .host_sel  (host_sel),
        .fifo_sel  (fifo_sel),
        .host_rw   (host_rw),
        .host_addr (host_addr),
        .host_data (host_data),
        .host_eof  (host_eof),
        .wreq      (wreq)
    );

    txb_thr_reg u_thr (
        .clk     (clk),
        .rst     (rst),
        .clr     (soft_rst),
        .load    (wreq.cfg),
        .code_in (wreq.code),
        .code_q  (code_q)
    );

    assign thr_n = thr_bytes(code_q);

    txb_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .clr     (soft_rst),
        .push    (wreq.push),
        .wr_ent  (wreq.ent),
        .take    (rd_ready),
        .head    (head),
        .valid   (rd_valid),
        .full    (full),
        .occ     (occ),
        .frames  (frames),
        .ovf     (overflow),
        .pop_eof (pop_eof)
    );

    txb_start_ctl #(.CNT_W(CNT_W)) u_start (
        .clk       (clk),
        .rst       (rst),
        .clr       (soft_rst),
        .occ       (occ),
        .frames    (frames),
        .full      (full),
        .thr_n     (thr_n),
        .pop_eof   (pop_eof),
        .start_req (start_req)
    );

    assign rd_data = head.data;
    assign rd_eof  = head.eof;
endmodule

// File: rtl/txb_checker.sv
module txb_checker #(
    parameter  int DEPTH = 136,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             soft_rst,
    input logic             host_sel,
    input logic             fifo_sel,
    input logic             rd_valid,
    input logic             rd_ready,
    input logic [7:0]       rd_data,
    input logic             start_req,
    input logic             overflow,
    input logic [CNT_W-1:0] occ,
    input logic [31:0]      thr_n
);
    assert_both_blocked_R4: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (host_sel && fifo_sel && !(rd_valid && rd_ready)) |=> (occ == $past(occ)));

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
        occ <= CNT_W'(DEPTH));

    assert_overflow_sticky_R11: assert property (@(posedge clk) disable iff (rst || soft_rst)
        overflow |=> overflow);

    assert_full_start_R10: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (occ == CNT_W'(DEPTH)) |-> start_req);

    assert_threshold_start_R8: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (32'(occ) >= thr_n) |-> start_req);

    assert_head_hold_R12: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (rd_valid && !rd_ready && !host_sel && !fifo_sel) |=> (rd_valid && $stable(rd_data)));

    assert_soft_clear_R13: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (!rd_valid && !overflow));
endmodule

bind tx_stage_buffer txb_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst),
    .host_sel  (host_sel),
    .fifo_sel  (fifo_sel),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .start_req (start_req),
    .overflow  (overflow),
    .occ       (occ),
    .thr_n     (thr_n)
);

// File: tb/sim_tx_stage_buffer.sv
module sim_tx_stage_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 136;

    logic clk = 1'b0;
    logic rst = 1'b1, soft_rst = 1'b0;
    logic host_sel = 1'b0, fifo_sel = 1'b0, host_rw = 1'b0, host_eof = 1'b0;
    logic [4:0] host_addr = '0;
    logic [7:0] host_data = '0;
    logic rd_ready = 1'b0;
    logic [7:0] rd_data;
    logic rd_eof, rd_valid, start_req, overflow;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_stage_buffer #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .host_sel(host_sel), .fifo_sel(fifo_sel), .host_rw(host_rw),
        .host_addr(host_addr), .host_data(host_data), .host_eof(host_eof),
        .rd_data(rd_data), .rd_eof(rd_eof), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .start_req(start_req), .overflow(overflow)
    );

    int n_chk = 0, n_fail = 0;
    string cur_req = "R13";

    logic [8:0] mq[$];
    bit m_ovf = 0, m_started = 0;
    logic [1:0] m_code = 2'b10;
    int m_frames = 0;

    function automatic int thr_of(logic [1:0] c);
        case (c)
            2'b00: return 4;
            2'b01: return 16;
            2'b10: return 64;
            default: return 112;
        endcase
    endfunction

    function automatic bit m_cond();
        return (m_frames > 0) || (mq.size() == DEPTH) || (mq.size() >= thr_of(m_code));
    endfunction

    task automatic check(string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic model_update();
        if (rst || soft_rst) begin
            mq.delete(); m_ovf = 0; m_started = 0; m_code = 2'b10; m_frames = 0;
        end else begin
            bit full, pop, pop_eof, push, cfg;
            full    = (mq.size() == DEPTH);
            pop     = rd_ready && (mq.size() > 0);
            pop_eof = pop && mq[0][8];
            push    = !host_rw && (host_sel != fifo_sel) && (fifo_sel || host_addr == 5'd1);
            cfg     = host_sel && !fifo_sel && !host_rw && host_addr == 5'd2;
            m_started = (m_started || m_cond()) && !pop_eof;
            if (pop) begin
                if (pop_eof) m_frames--;
                void'(mq.pop_front());
            end
            if (push) begin
                if (full) m_ovf = 1;
                else begin
                    mq.push_back({host_eof, host_data});
                    if (host_eof) m_frames++;
                end
            end
            if (cfg) m_code = host_data[1:0];
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        model_update();
        check("rd_valid", {7'd0, rd_valid}, {7'd0, mq.size() > 0});
        if (mq.size() > 0) begin
            check("rd_data", rd_data, mq[0][7:0]);
            check("rd_eof", {7'd0, rd_eof}, {7'd0, mq[0][8]});
        end
        check("start_req", {7'd0, start_req}, {7'd0, m_started || m_cond()});
        check("overflow", {7'd0, overflow}, {7'd0, m_ovf});
    endtask

    task automatic set_idle();
        host_sel = 0; fifo_sel = 0; host_rw = 0; host_eof = 0; rd_ready = 0; soft_rst = 0;
    endtask

    task automatic wr_addr(logic [4:0] a, logic [7:0] d, logic e);
        host_sel = 1; fifo_sel = 0; host_rw = 0; host_addr = a; host_data = d; host_eof = e;
        step(); set_idle();
    endtask

    task automatic wr_dir(logic [7:0] d, logic e);
        host_sel = 0; fifo_sel = 1; host_rw = 0; host_addr = 5'($urandom); host_data = d; host_eof = e;
        step(); set_idle();
    endtask

    task automatic pops(int n);
        for (int i = 0; i < n; i++) begin rd_ready = 1; step(); end
        set_idle();
    endtask

    task automatic do_srst();
        soft_rst = 1; step(); set_idle();
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        // reset state (R13)
        step(); step();
        rst = 0;
        step();

        // R1 + R5: back-to-back addressed writes
        cur_req = "R1";
        for (int i = 0; i < 5; i++) wr_addr(5'd1, 8'h10 + 8'(i), 1'b0);
        cur_req = "R5";
        step();
        // R2: read cycles and other addresses ignored
        cur_req = "R2";
        host_sel = 1; host_rw = 1; host_addr = 5'd1; host_data = 8'hEE; step(); set_idle();
        wr_addr(5'd3, 8'hEF, 1'b0);
        wr_addr(5'd0, 8'hF0, 1'b1);
        wr_addr(5'd31, 8'hF1, 1'b1);
        step();
        // R3: direct writes at any address
        cur_req = "R3";
        for (int i = 0; i < 4; i++) wr_dir(8'h40 + 8'(i), 1'b0);
        // R4: both strobes active
        cur_req = "R4";
        host_sel = 1; fifo_sel = 1; host_addr = 5'd1; host_data = 8'h99; host_eof = 1; step();
        host_addr = 5'd2; host_data = 8'h00; step(); set_idle();
        step();
        // R6: drain in order
        cur_req = "R6";
        pops(12);

        // R7 / R8: every threshold code, one below then at threshold
        for (int c = 0; c < 4; c++) begin
            cur_req = "R7";
            do_srst();
            if (c != 2) wr_addr(5'd2, 8'(c), 1'b0);
            cur_req = (c == 2) ? "R8" : "R7";
            for (int i = 0; i < thr_of(2'(c)); i++) wr_dir(8'(i), 1'b0);
            step();
        end

        // R9: short complete frame under large threshold
        cur_req = "R9";
        do_srst();
        wr_addr(5'd1, 8'hA1, 1'b0);
        wr_addr(5'd1, 8'hA2, 1'b0);
        wr_addr(5'd1, 8'hA3, 1'b1);
        step();
        pops(3);

        // R10 / R11: fill to capacity then overflow
        cur_req = "R10";
        do_srst();
        wr_addr(5'd2, 8'h03, 1'b0);
        for (int i = 0; i < DEPTH; i++) wr_dir(8'(i * 3), 1'b0);
        cur_req = "R11";
        wr_dir(8'h55, 1'b1);
        wr_addr(5'd1, 8'h56, 1'b0);
        step();
        pops(1);
        step();

        // R13: soft reset clears everything mid-state
        cur_req = "R13";
        do_srst();
        step();

        // R14: grant held after count falls below threshold
        cur_req = "R14";
        wr_addr(5'd2, 8'h00, 1'b0);
        for (int i = 0; i < 4; i++) wr_dir(8'h70 + 8'(i), 1'b0);
        pops(3);
        step();
        wr_dir(8'h7F, 1'b1);
        pops(2);
        step();

        // R6 / R12: random mix
        cur_req = "R12";
        for (int k = 0; k < 6000; k++) begin
            int r;
            r = int'($urandom % 16);
            host_sel  = (r < 6) || (r == 14);
            fifo_sel  = (r >= 6 && r < 12) || (r == 14);
            host_rw   = ($urandom % 8) == 0;
            host_addr = (r < 3) ? 5'd1 : (r == 3) ? 5'd2 : 5'($urandom);
            host_data = 8'($urandom);
            host_eof  = ($urandom % 10) == 0;
            rd_ready  = ($urandom % 2) == 0;
            soft_rst  = ($urandom % 700) == 0;
            cur_req   = (k % 2 == 0) ? "R6" : "R12";
            step();
        end
        set_idle();
        step();
        report();
    end
endmodule